// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a memory-mapped real-time seconds counter. A free-running one-pulse-per-second strobe, produced elsewhere on the chip, advances an unsigned seconds count while the counter is switched on. Software sets the time by writing a load register. The new value does not appear at once: it replaces the increment at the next one-second update.

A match register holds an alarm time. When an update brings the count to the match value, a sticky alarm event is latched. The event can be seen in two status views. The raw view ignores the enable and mask bits, and the masked view is the same level that drives the interrupt pin. Software acknowledges the alarm by reading an end-of-interrupt word, and the read itself clears the event.

The bus is a plain 32-bit register port with word addresses. Writes take effect at the clock edge of the write cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `secs_alarm_timer`

## Requirements
- R1: After reset the count, match, load and control registers read 0, the raw alarm status reads 0 and `irq_o` is low.
- R2: On each cycle with `pps_tick_i` high and control bit 2 (counter on) set, the count rises by one. With bit 2 clear, or with no tick, the count keeps its value. Writes to the count word (word address 0) are ignored.
- R3: A write to the load word (word address 2) leaves the count unchanged until the next applied tick, which sets the count to the loaded value instead of incrementing. When several loads come before that tick, the last written value is used.
- R4: An applied tick with the count at all-ones sets it to zero when control bit 3 (rollover) is set, and leaves it at all-ones when bit 3 is clear.
- R5: An applied tick whose resulting count equals the match word (word address 1) latches the alarm event. Bit 0 of the raw status word (word address 5) then reads 1 whatever the values of control bits 0 and 1.
- R6: `irq_o` and bit 0 of the masked status word (word address 4) are high exactly when the alarm event is latched, control bit 0 (alarm enable) is set and control bit 1 (alarm mask) is clear.
- R7: A read of the end-of-interrupt word (word address 6) returns 0 and clears the latched alarm event. A write to that word has no effect on the event.
- R8: The version word (word address 7) reads the `VERSION` parameter. Writes to the status, raw status and version words are ignored, and reads of word addresses 8 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_tick_i | input | 1 | One-cycle strobe, once per second |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W (4) | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 4-bit word address and the default version constant. With this build the full count width is exercised. A load of values just below all-ones lets both the rollover and the saturating hold be reached in a few ticks, without counting through 2^32 seconds. The 4-bit address also reaches word addresses 8 to 15, which are unmapped, so the read-as-zero decode is checked as well.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;

  localparam int unsigned WORD_W = 32;

  // Word-address map seen by software.
  typedef enum logic [2:0] {
    RA_COUNT = 3'd0,
    RA_MATCH = 3'd1,
    RA_LOAD  = 3'd2,
    RA_CTRL  = 3'd3,
    RA_STAT  = 3'd4,
    RA_RAW   = 3'd5,
    RA_EOI   = 3'd6,
    RA_VER   = 3'd7
  } reg_sel_e;

  // Control word layout: bit3 rollover, bit2 counter on, bit1 mask, bit0 enable.
  typedef struct packed {
    logic wrap_en;
    logic cnt_en;
    logic irq_mask;
    logic irq_en;
  } ctrl_t;

  // Interrupt level from the latched event and the control bits.
  function automatic logic alarm_level(input logic pend, input ctrl_t c);
    return pend & c.irq_en & ~c.irq_mask;
  endfunction

endpackage

// File: rtl/sec_counter.sv
module sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_en_i,
  input  logic             wrap_en_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             update_o
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  // One-second step: increment, roll over or hold at the top.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic wrap);
    if (cur == ALL_ONES) return wrap ? '0 : cur;
    return cur + 1'b1;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val_q;
  logic             load_pend_q;
  logic             apply_tick;

  assign apply_tick = tick_i & cnt_en_i;
  assign cnt_next_o = load_pend_q ? load_val_q : step_count(count_q, wrap_en_i);
  assign update_o   = apply_tick;
  assign count_o    = count_q;
  assign load_val_o = load_val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (apply_tick) begin
      count_q <= cnt_next_o;
    end
  end

  // A write in the tick cycle stays pending for the following tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_val_q  <= '0;
      load_pend_q <= 1'b0;
    end else if (load_wr_i) begin
      load_val_q  <= load_data_i;
      load_pend_q <= 1'b1;
    end else if (apply_tick) begin
      load_pend_q <= 1'b0;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_tick && !load_pend_q && count_q != ALL_ONES) |=> count_q == $past(count_q) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_tick |=> $stable(count_q));

  assert_load_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_tick && load_pend_q) |=> count_q == $past(load_val_q));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_tick && !load_pend_q && count_q == ALL_ONES && wrap_en_i) |=> count_q == '0);

  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_tick && !load_pend_q && count_q == ALL_ONES && !wrap_en_i) |=> count_q == ALL_ONES);

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import secs_alarm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_wr_i,
  input  logic [CNT_W-1:0] match_data_i,
  input  logic             update_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             eoi_rd_i,
  input  ctrl_t            ctrl_i,
  output logic [CNT_W-1:0] match_o,
  output logic             pend_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] match_q;
  logic             pend_q;
  logic             match_evt;

  // The event is judged on the value the count takes at this update.
  assign match_evt = update_i & (cnt_next_i == match_q);
  assign match_o   = match_q;
  assign pend_o    = pend_q;
  assign irq_o     = alarm_level(pend_q, ctrl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (match_wr_i) begin
      match_q <= match_data_i;
    end
  end

  // A new event in the acknowledge cycle wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (match_evt) begin
      pend_q <= 1'b1;
    end else if (eoi_rd_i) begin
      pend_q <= 1'b0;
    end
  end

  assert_evt_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> pend_q);

  assert_eoi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_rd_i && !match_evt) |=> !pend_q);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !match_evt) |=> !pend_q);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.irq_en || ctrl_i.irq_mask || !pend_q) |-> !irq_o);

endmodule

// File: rtl/reg_port.sv
module reg_port
  import secs_alarm_pkg::*;
#(
  parameter int unsigned     CNT_W   = 32,
  parameter int unsigned     ADDR_W  = 4,
  parameter logic [WORD_W-1:0] VERSION = 32'h0001_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  match_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              pend_i,
  input  logic              irq_i,
  output ctrl_t             ctrl_o,
  output logic              load_wr_o,
  output logic              match_wr_o,
  output logic              eoi_rd_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic     in_map;
  reg_sel_e sel;
  ctrl_t    ctrl_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_mux;
  logic     unused_wdata;

  generate
    if (ADDR_W > 3) begin : g_wide
      assign in_map = ~|addr_i[ADDR_W-1:3];
    end else begin : g_narrow
      assign in_map = 1'b1;
    end
  endgenerate

  assign sel          = reg_sel_e'(addr_i[2:0]);
  assign load_wr_o    = wr_i & in_map & (sel == RA_LOAD);
  assign match_wr_o   = wr_i & in_map & (sel == RA_MATCH);
  assign eoi_rd_o     = rd_i & in_map & (sel == RA_EOI);
  assign ctrl_o       = ctrl_q;
  assign rdata_o      = rdata_q;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_i && in_map && sel == RA_CTRL) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      unique case (sel)
        RA_COUNT: rd_mux = WORD_W'(count_i);
        RA_MATCH: rd_mux = WORD_W'(match_i);
        RA_LOAD:  rd_mux = WORD_W'(load_val_i);
        RA_CTRL:  rd_mux = WORD_W'(ctrl_q);
        RA_STAT:  rd_mux = WORD_W'(irq_i);
        RA_RAW:   rd_mux = WORD_W'(pend_i);
        RA_EOI:   rd_mux = '0;
        RA_VER:   rd_mux = VERSION;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_mux;
    end
  end

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !in_map) |=> rdata_q == '0);

  assert_ctrl_only_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q));

endmodule

// File: rtl/secs_alarm_timer.sv
module secs_alarm_timer
  import secs_alarm_pkg::*;
#(
  parameter int unsigned       CNT_W   = 32,
  parameter int unsigned       ADDR_W  = 4,
  parameter logic [WORD_W-1:0] VERSION = 32'h0001_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);

  ctrl_t            ctrl;
  logic             load_wr;
  logic             match_wr;
  logic             eoi_rd;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] match_val;
  logic             update;
  logic             pend;

  reg_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .count_i    (count),
    .match_i    (match_val),
    .load_val_i (load_val),
    .pend_i     (pend),
    .irq_i      (irq_o),
    .ctrl_o     (ctrl),
    .load_wr_o  (load_wr),
    .match_wr_o (match_wr),
    .eoi_rd_o   (eoi_rd),
    .rdata_o    (bus_rdata_o)
  );

  sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (pps_tick_i),
    .cnt_en_i    (ctrl.cnt_en),
    .wrap_en_i   (ctrl.wrap_en),
    .load_wr_i   (load_wr),
    .load_data_i (bus_wdata_i[CNT_W-1:0]),
    .count_o     (count),
    .load_val_o  (load_val),
    .cnt_next_o  (cnt_next),
    .update_o    (update)
  );

  alarm_unit #(.CNT_W(CNT_W)) u_alarm (
    .clk          (clk),
    .rst_n        (rst_n),
    .match_wr_i   (match_wr),
    .match_data_i (bus_wdata_i[CNT_W-1:0]),
    .update_i     (update),
    .cnt_next_i   (cnt_next),
    .eoi_rd_i     (eoi_rd),
    .ctrl_i       (ctrl),
    .match_o      (match_val),
    .pend_o       (pend),
    .irq_o        (irq_o)
  );

endmodule

// File: tb/sim_secs_alarm_timer.sv
`timescale 1ns/1ps
module sim_secs_alarm_timer;

  localparam int ADDR_W = 4;
  localparam logic [31:0] VER = 32'h0001_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps = 1'b0;
  logic wr = 1'b0;
  logic rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secs_alarm_timer #(.CNT_W(32), .ADDR_W(ADDR_W), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_tick_i(pps), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_word(input int a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = ADDR_W'(a);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); pps = 1'b1;
    @(negedge clk); pps = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_word(0, d); check("R1 count", d, 0);
    rd_word(1, d); check("R1 match", d, 0);
    rd_word(2, d); check("R1 load", d, 0);
    rd_word(3, d); check("R1 ctrl", d, 0);
    rd_word(5, d); check("R1 raw", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    tick(); rd_word(0, d); check("R2 off no count", d, 0);
    wr_word(3, 32'h4);
    repeat (3) tick();
    rd_word(0, d); check("R2 three ticks", d, 3);
    repeat (5) @(negedge clk);
    rd_word(0, d); check("R2 no tick hold", d, 3);
    wr_word(3, 32'h0); tick();
    rd_word(0, d); check("R2 disabled hold", d, 3);
    wr_word(3, 32'h4);
    wr_word(0, 32'h55); rd_word(0, d); check("R2 count write ignored", d, 3);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr_word(2, 100);
    rd_word(0, d); check("R3 load deferred", d, 3);
    wr_word(2, 200);
    tick(); rd_word(0, d); check("R3 last load wins", d, 200);
    tick(); rd_word(0, d); check("R3 increment after load", d, 201);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr_word(1, 32'h1234);
    wr_word(3, 32'hC);
    wr_word(2, 32'hFFFF_FFFE);
    tick(); tick();
    rd_word(0, d); check("R4 reach top", d, 32'hFFFF_FFFF);
    tick(); rd_word(0, d); check("R4 rollover", d, 0);
    wr_word(3, 32'h4);
    wr_word(2, 32'hFFFF_FFFF);
    tick(); tick();
    rd_word(0, d); check("R4 saturate", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    rd_word(6, d);
    wr_word(3, 32'h4);
    wr_word(2, 10); tick();
    wr_word(1, 12);
    tick(); rd_word(5, d); check("R5 no match yet", d, 0);
    tick(); rd_word(5, d); check("R5 raw set disabled", d, 1);
    check("R6 irq off when disabled", {31'b0, irq}, 0);
    rd_word(4, d); check("R6 status off when disabled", d, 0);
    wr_word(3, 32'h5);
    check("R6 irq on", {31'b0, irq}, 1);
    rd_word(4, d); check("R6 status on", d, 1);
    wr_word(3, 32'h7);
    check("R6 irq masked", {31'b0, irq}, 0);
    rd_word(5, d); check("R5 raw while masked", d, 1);
    wr_word(3, 32'h5);
    check("R6 irq unmasked", {31'b0, irq}, 1);
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    wr_word(6, 32'hFFFF_FFFF);
    rd_word(5, d); check("R7 eoi write no clear", d, 1);
    rd_word(6, d); check("R7 eoi reads zero", d, 0);
    rd_word(5, d); check("R7 raw cleared", d, 0);
    check("R7 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    rd_word(7, d); check("R8 version", d, VER);
    wr_word(7, 32'hDEAD_BEEF);
    rd_word(7, d); check("R8 version write ignored", d, VER);
    wr_word(5, 32'h1);
    rd_word(5, d); check("R8 raw write ignored", d, 0);
    wr_word(4, 32'h1);
    rd_word(4, d); check("R8 status write ignored", d, 0);
    rd_word(9, d); check("R8 unmapped zero", d, 0);
    rd_word(15, d); check("R8 unmapped top zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_load();
    t_wrap();
    t_alarm();
    t_eoi();
    t_misc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule